// File: doc/BRIEF.md
# Block copy and search engine

This engine runs byte-block operations for a processor core so the core does not have to loop over them. The core supplies a source pointer, a destination pointer, a byte count, a compare value and its current flag byte, then pulses `start` with a command. The command has three fields: copy or compare, one step or repeat, and increment or decrement. The engine then reaches memory through a single byte port with a request/acknowledge handshake. When the command finishes it pulses `done` for one cycle. At that point the updated pointers, the counter and the new flag byte are presented for the core to write back.

A copy moves one byte from the source address to the destination address. A compare reads one byte at the source address and derives flags from the compare value minus that byte. Both kinds move their pointers by one and decrement the counter modulo 2^16. A repeated copy stops when the counter runs out. A repeated compare also stops on the first byte equal to the compare value.

The controller is one state machine with five states:
- `ST_IDLE` waits for `start`.
- `ST_READ` holds a read request at the source pointer until it is acknowledged.
- `ST_WRITE` holds a write request of the captured byte at the destination pointer until it is acknowledged. Copies only.
- `ST_STEP` moves the pointers, decrements the counter, updates the flags and decides whether to continue.
- `ST_DONE` raises `done` for one cycle.

The transitions are:
- IDLE to READ on `start`.
- READ to WRITE (copy) or READ to STEP (compare) on `mem_ack`.
- WRITE to STEP on `mem_ack`.
- STEP to READ when repeating and no stop condition holds, otherwise STEP to DONE.
- DONE to IDLE unconditionally.

Top module: `blkmove_engine`

## Requirements
- R1: A `start` seen in `ST_IDLE` latches every operand and the command. `busy` is 1 from the next cycle until `done`. A `start` while busy has no effect on the result.
- R2: At most one memory access is outstanding. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`. A copy reads the source byte before writing it.
- R3: A copy step writes the byte read at the source pointer to the destination pointer. Both pointers then move by one (down when `cmd_down`=1, up otherwise) and the counter decrements by one.
- R4: The counter decrement is modulo 2^16, so a count of 0 becomes 0xFFFF. A repeated copy continues until the counter reaches 0, and the number of writes equals the starting count.
- R5: Flag byte layout: bit 7 sign, bit 6 zero, bit 4 half-carry, bit 2 count-nonzero, bit 1 subtract, bit 0 carry. A copy step clears bits 4 and 1 and keeps bits 7, 6, 5, 3 and 0 from `flags_in`.
- R6: A compare step reads only the source byte. It never writes, moves only the source pointer and decrements the counter. `dst_out` equals `dst_in`.
- R7: A compare step forms d = compare value minus byte, 8 bits. It sets bit 7 to d[7], bit 6 to (d==0), bit 4 to the borrow out of the low nibble (compare[3:0] < byte[3:0]) and bit 1 to 1. Bits 5, 3 and 0 keep their previous value.
- R8: A repeated compare ends after the first step whose byte equals the compare value, or after the step that brings the counter to 0, whichever comes first.
- R9: After every step, bit 2 of the flag byte is 1 when the decremented counter is nonzero and 0 otherwise.
- R10: `done` is a single-cycle pulse with `mem_req` and `busy` low. `src_out`, `dst_out`, `cnt_out` and `flags_out` hold the final values while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (accepted in idle only) |
| cmd_search | input | 1 | 1 = compare, 0 = copy |
| cmd_rep | input | 1 | 1 = repeat until a stop condition, 0 = one step |
| cmd_down | input | 1 | 1 = pointers decrement, 0 = increment |
| src_in | input | AW | Starting source pointer |
| dst_in | input | AW | Starting destination pointer |
| cnt_in | input | CW | Starting byte counter |
| key_in | input | DW | Compare value |
| flags_in | input | 8 | Flag byte before the command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| src_out | output | AW | Current/final source pointer |
| dst_out | output | AW | Current/final destination pointer |
| cnt_out | output | CW | Current/final counter |
| flags_out | output | 8 | Current/final flag byte |

## Verification
In a repeated compare, the data-match stop and the counter-exhaustion stop can fall on the same step: the last byte in range equals the compare value. The bench sweeps the match position over every offset of blocks of one to five bytes in both directions, so the match lands on the final byte in one case of each sweep. For that case the expected result is a zero flag of 1 together with a count-nonzero bit of 0 and a counter of 0. Every other position must stop early with the count-nonzero bit at 1.

// File: rtl/blkmove_pkg.sv
`timescale 1ns/1ps
package blkmove_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_STEP,
        ST_DONE
    } eng_state_t;

    typedef struct packed {
        logic search;
        logic rep;
        logic down;
    } cmd_t;

    localparam int FL_S  = 7;
    localparam int FL_Z  = 6;
    localparam int FL_H  = 4;
    localparam int FL_PV = 2;
    localparam int FL_N  = 1;
    localparam int FL_C  = 0;
    localparam int FLAG_W = 8;

endpackage

// File: rtl/blkmove_fsm.sv
`timescale 1ns/1ps
module blkmove_fsm
    import blkmove_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       search,
    input  logic       rep,
    input  logic       mem_ack,
    input  logic       last,
    input  logic       hit,
    output eng_state_t state,
    output logic       busy,
    output logic       done,
    output logic       mem_req,
    output logic       mem_we,
    output logic       load,
    output logic       capture,
    output logic       step_en
);

    eng_state_t nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_READ;
            ST_READ:  if (mem_ack) nxt = search ? ST_STEP : ST_WRITE;
            ST_WRITE: if (mem_ack) nxt = ST_STEP;
            ST_STEP:  nxt = (rep && !last && !(search && hit)) ? ST_READ : ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        load    = 1'b0;
        capture = 1'b0;
        step_en = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load = start;
            end
            ST_READ: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                capture = mem_ack;
            end
            ST_WRITE: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_STEP: begin
                busy    = 1'b1;
                step_en = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/blkmove_flagcalc.sv
`timescale 1ns/1ps
module blkmove_flagcalc
    import blkmove_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              search,
    input  logic              more,
    input  logic [FLAG_W-1:0] flags_cur,
    input  logic [DW-1:0]     key,
    input  logic [DW-1:0]     data,
    output logic [FLAG_W-1:0] flags_nxt,
    output logic              hit
);

    localparam int NIB = 4;

    logic [DW-1:0] diff;
    logic          nib_borrow;

    assign diff       = key - data;
    assign nib_borrow = key[NIB-1:0] < data[NIB-1:0];
    assign hit        = (key == data);

    always_comb begin
        flags_nxt        = flags_cur;
        flags_nxt[FL_PV] = more;
        if (search) begin
            flags_nxt[FL_S] = diff[DW-1];
            flags_nxt[FL_Z] = (diff == '0);
            flags_nxt[FL_H] = nib_borrow;
            flags_nxt[FL_N] = 1'b1;
        end else begin
            flags_nxt[FL_H] = 1'b0;
            flags_nxt[FL_N] = 1'b0;
        end
    end

endmodule

// File: rtl/blkmove_regs.sv
`timescale 1ns/1ps
module blkmove_regs
    import blkmove_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic              step_en,
    input  cmd_t              cmd_in,
    input  logic [AW-1:0]     src_in,
    input  logic [AW-1:0]     dst_in,
    input  logic [CW-1:0]     cnt_in,
    input  logic [DW-1:0]     key_in,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [DW-1:0]     rdata,
    input  logic [FLAG_W-1:0] flags_nxt,
    output cmd_t              cmd,
    output logic [AW-1:0]     src,
    output logic [AW-1:0]     dst,
    output logic [CW-1:0]     cnt,
    output logic [DW-1:0]     key,
    output logic [DW-1:0]     data,
    output logic [FLAG_W-1:0] flags,
    output logic              more,
    output logic              last
);

    logic [CW-1:0] cnt_dec;

    function automatic logic [AW-1:0] nudge(input logic [AW-1:0] p, input logic dn);
        return dn ? p - 1'b1 : p + 1'b1;
    endfunction

    assign cnt_dec = cnt - 1'b1;
    assign last    = (cnt_dec == '0);
    assign more    = !last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd   <= '0;
            src   <= '0;
            dst   <= '0;
            cnt   <= '0;
            key   <= '0;
            data  <= '0;
            flags <= '0;
        end else if (load) begin
            cmd   <= cmd_in;
            src   <= src_in;
            dst   <= dst_in;
            cnt   <= cnt_in;
            key   <= key_in;
            flags <= flags_in;
        end else begin
            if (capture) begin
                data <= rdata;
            end
            if (step_en) begin
                src   <= nudge(src, cmd.down);
                cnt   <= cnt_dec;
                flags <= flags_nxt;
                if (!cmd.search) begin
                    dst <= nudge(dst, cmd.down);
                end
            end
        end
    end

endmodule

// File: rtl/blkmove_engine.sv
`timescale 1ns/1ps
module blkmove_engine
    import blkmove_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cmd_search,
    input  logic          cmd_rep,
    input  logic          cmd_down,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    input  logic [DW-1:0] key_in,
    input  logic [7:0]    flags_in,
    output logic          busy,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic [AW-1:0] src_out,
    output logic [AW-1:0] dst_out,
    output logic [CW-1:0] cnt_out,
    output logic [7:0]    flags_out
);

    eng_state_t        state;
    cmd_t              cmd_in;
    cmd_t              cmd;
    logic              load, capture, step_en;
    logic              more, last, hit;
    logic              mode_search, mode_rep;
    logic [DW-1:0]     key, data;
    logic [FLAG_W-1:0] flags, flags_nxt;

    assign cmd_in      = '{search: cmd_search, rep: cmd_rep, down: cmd_down};
    assign mode_search = cmd.search;
    assign mode_rep    = cmd.rep;

    blkmove_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .search  (mode_search),
        .rep     (mode_rep),
        .mem_ack (mem_ack),
        .last    (last),
        .hit     (hit),
        .state   (state),
        .busy    (busy),
        .done    (done),
        .mem_req (mem_req),
        .mem_we  (mem_we),
        .load    (load),
        .capture (capture),
        .step_en (step_en)
    );

    blkmove_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .capture   (capture),
        .step_en   (step_en),
        .cmd_in    (cmd_in),
        .src_in    (src_in),
        .dst_in    (dst_in),
        .cnt_in    (cnt_in),
        .key_in    (key_in),
        .flags_in  (flags_in),
        .rdata     (mem_rdata),
        .flags_nxt (flags_nxt),
        .cmd       (cmd),
        .src       (src_out),
        .dst       (dst_out),
        .cnt       (cnt_out),
        .key       (key),
        .data      (data),
        .flags     (flags),
        .more      (more),
        .last      (last)
    );

    blkmove_flagcalc #(.DW(DW)) u_flag (
        .search    (mode_search),
        .more      (more),
        .flags_cur (flags),
        .key       (key),
        .data      (data),
        .flags_nxt (flags_nxt),
        .hit       (hit)
    );

    assign mem_addr  = (state == ST_WRITE) ? dst_out : src_out;
    assign mem_wdata = data;
    assign flags_out = flags;

endmodule

// File: rtl/blkmove_engine_chk.sv
`timescale 1ns/1ps
module blkmove_engine_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] cnt_out,
    input logic [7:0]    flags_out,
    input logic          mode_search,
    input logic          mode_rep
);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req && !busy);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_pv_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> flags_out[2] == (cnt_out != '0));

    assert_copy_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done && !mode_search && mode_rep |-> cnt_out == '0);

    assert_early_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && mode_search && mode_rep && cnt_out != '0 |-> flags_out[6]);

    assert_cmp_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done && mode_search |-> flags_out[1]);

    assert_copy_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done && !mode_search |-> !flags_out[1] && !flags_out[4]);

endmodule

bind blkmove_engine blkmove_engine_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .busy        (busy),
    .done        (done),
    .cnt_out     (cnt_out),
    .flags_out   (flags_out),
    .mode_search (mode_search),
    .mode_rep    (mode_rep)
);

// File: tb/blkmove_engine_tb.sv
`timescale 1ns/1ps
module blkmove_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmd_search = 1'b0, cmd_rep = 1'b0, cmd_down = 1'b0;
    logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
    logic [7:0]  key_in = '0, flags_in = '0;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_ack;
    logic [15:0] src_out, dst_out, cnt_out;
    logic [7:0]  flags_out;

    int total = 0;
    int bad = 0;

    // memory model state
    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];
    int  lat = 0;
    int  wcnt = 0;
    int  wr_count = 0;
    int  rd_count = 0;
    logic       fill_go = 1'b0;
    logic [7:0] fill_seed = '0;

    always #2.5 clk = ~clk;

    blkmove_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_search(cmd_search), .cmd_rep(cmd_rep), .cmd_down(cmd_down),
        .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
        .key_in(key_in), .flags_in(flags_in),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .src_out(src_out), .dst_out(dst_out),
        .cnt_out(cnt_out), .flags_out(flags_out)
    );

    function automatic logic [7:0] pat(input int i, input logic [7:0] seed);
        return 8'((i * 37) + (seed * 11) + (i >> 2));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            wcnt      <= 0;
        end else if (fill_go) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i, fill_seed);
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[7:0]] <= mem_wdata;
                    wr_count <= wr_count + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[7:0]];
                    rd_count  <= rd_count + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] seed);
        @(negedge clk);
        fill_seed = seed;
        fill_go   = 1'b1;
        for (int i = 0; i < 256; i++) ref_mem[i] = pat(i, seed);
        @(negedge clk);
        fill_go = 1'b0;
    endtask

    // reference model from the requirements
    task automatic model(input bit srch, input bit rep, input bit dn,
                         input logic [15:0] s0, input logic [15:0] d0,
                         input logic [15:0] c0, input logic [7:0] k,
                         input logic [7:0] f0,
                         output logic [15:0] es, output logic [15:0] ed,
                         output logic [15:0] ec, output logic [7:0] ef,
                         output int nwr, output int nrd);
        logic [7:0] b;
        logic [7:0] dd;
        bit stop;
        es = s0; ed = d0; ec = c0; ef = f0; nwr = 0; nrd = 0;
        do begin
            b = ref_mem[es[7:0]];
            nrd++;
            if (!srch) begin
                ref_mem[ed[7:0]] = b;
                nwr++;
                ed = dn ? ed - 16'd1 : ed + 16'd1;
            end
            es = dn ? es - 16'd1 : es + 16'd1;
            ec = ec - 16'd1;
            if (srch) begin
                dd = k - b;
                ef[7] = dd[7];
                ef[6] = (dd == 8'h00);
                ef[4] = (k[3:0] < b[3:0]);
                ef[1] = 1'b1;
            end else begin
                ef[4] = 1'b0;
                ef[1] = 1'b0;
            end
            ef[2] = (ec != 16'h0000);
            stop = !rep || (ec == 16'h0000) || (srch && (b == k));
        end while (!stop);
    endtask

    task automatic run(input string tag, input bit srch, input bit rep, input bit dn,
                       input logic [15:0] s0, input logic [15:0] d0,
                       input logic [15:0] c0, input logic [7:0] k,
                       input logic [7:0] f0, input int lat_v, input bit disturb);
        logic [15:0] es, ed, ec;
        logic [7:0]  ef;
        int nwr, nrd, wr0, rd0, waited, mism;
        model(srch, rep, dn, s0, d0, c0, k, f0, es, ed, ec, ef, nwr, nrd);
        @(negedge clk);
        lat = lat_v;
        wr0 = wr_count; rd0 = rd_count;
        cmd_search = srch; cmd_rep = rep; cmd_down = dn;
        src_in = s0; dst_in = d0; cnt_in = c0; key_in = k; flags_in = f0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R1 busy after start"}, 32'(busy), 32'd1);
        if (disturb) begin
            @(negedge clk);
            @(negedge clk);
            cmd_search = ~srch; cmd_rep = 1'b0; cmd_down = ~dn;
            src_in = 16'h00F0; dst_in = 16'h0011; cnt_in = 16'h0003;
            key_in = ~k; flags_in = ~f0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        check({tag, " R10 done seen"}, 32'(done), 32'd1);
        check({tag, " R10 busy low at done"}, 32'(busy), 32'd0);
        check({tag, " R3/R6 src_out"}, 32'(src_out), 32'(es));
        check({tag, " R3/R6 dst_out"}, 32'(dst_out), 32'(ed));
        check({tag, " R4 cnt_out"}, 32'(cnt_out), 32'(ec));
        check({tag, " R5/R7/R9 flags_out"}, 32'(flags_out), 32'(ef));
        check({tag, " R4/R6 write count"}, 32'(wr_count - wr0), 32'(nwr));
        check({tag, " R2/R8 read count"}, 32'(rd_count - rd0), 32'(nrd));
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) mism++;
        check({tag, " R3/R6 memory image"}, 32'(mism), 32'd0);
        @(negedge clk);
        check({tag, " R10 done single cycle"}, 32'(done), 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] fl [4];
        fl[0] = 8'h00; fl[1] = 8'hFF; fl[2] = 8'hA5; fl[3] = 8'h69;
        repeat (3) @(negedge clk);
        // reset state
        check("R1 reset busy", 32'(busy), 32'd0);
        check("R10 reset done", 32'(done), 32'd0);
        check("R2 reset mem_req", 32'(mem_req), 32'd0);
        check("R4 reset cnt_out", 32'(cnt_out), 32'd0);
        check("R5 reset flags_out", 32'(flags_out), 32'd0);
        rst_n = 1'b1;
        fill(8'h03);

        // single copy steps: R3 R5 R9
        for (int dn = 0; dn < 2; dn++)
            for (int la = 0; la < 3; la++)
                for (int c = 1; c < 4; c++)
                    run("copy1 R3", 1'b0, 1'b0, dn[0], 16'h0040 + 16'(c), 16'h0090,
                        16'(c), 8'h00, fl[(c + la) % 4], la, 1'b0);

        // repeated copy sweep: R4 R5 R9
        fill(8'h17);
        for (int dn = 0; dn < 2; dn++)
            for (int c = 1; c < 7; c++)
                run("copyN R4", 1'b0, 1'b1, dn[0], 16'h0020, 16'h00A0 + 16'(c * 8),
                    16'(c), 8'h00, fl[c % 4], c % 2, 1'b0);

        // count 0 wraps: R4
        run("copy1 count0 R4", 1'b0, 1'b0, 1'b0, 16'h0010, 16'h0070, 16'h0000,
            8'h00, 8'h29, 0, 1'b0);
        // pointer wrap downward from zero: R3
        run("copy1 wrap R3", 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0002,
            8'h00, 8'h01, 1, 1'b0);

        // single compare across keys: R6 R7
        fill(8'h5C);
        for (int kk = 0; kk < 256; kk += 17)
            run("cmp1 R7", 1'b1, 1'b0, kk[0], 16'h0030, 16'h1234, 16'h0005,
                8'(kk), fl[kk % 4], kk % 3, 1'b0);

        // repeated compare, match at every position: R8 R9
        for (int dn = 0; dn < 2; dn++)
            for (int n = 1; n < 6; n++)
                for (int p = 0; p < n; p++) begin
                    logic [15:0] s0;
                    logic [15:0] tgt;
                    s0  = 16'h0050;
                    tgt = dn ? s0 - 16'(p) : s0 + 16'(p);
                    run("cmpN match R8", 1'b1, 1'b1, dn[0], s0, 16'h0000, 16'(n),
                        ref_mem[tgt[7:0]], fl[p % 4], p % 2, 1'b0);
                end

        // repeated compare without a match in range: R8
        run("cmpN nomatch R8", 1'b1, 1'b1, 1'b0, 16'h0060, 16'h0000, 16'h0004,
            8'hEE, 8'h80, 0, 1'b0);

        // count 0 repeated compare stops on a match: R4 R8
        run("cmpN count0 R4", 1'b1, 1'b1, 1'b0, 16'h0070, 16'h0000, 16'h0000,
            ref_mem[8'h72], 8'h00, 0, 1'b0);

        // start while busy has no effect: R1
        fill(8'h21);
        run("copyN restart R1", 1'b0, 1'b1, 1'b0, 16'h0008, 16'h0080, 16'h0006,
            8'h00, 8'hC3, 1, 1'b1);
        run("cmpN restart R1", 1'b1, 1'b1, 1'b1, 16'h00C0, 16'h0000, 16'h0008,
            8'hEE, 8'h01, 2, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule